// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block holds a small set of recent virtual-to-physical page mappings. Every stored entry is compared against the page number of the incoming virtual address at the same time. If an entry matches and the requested access is allowed, the physical address is produced combinationally in the same cycle. It is formed from the stored physical page number and the untouched in-page offset.

The block reports a protection fault instead of a translation in several cases. The fault is raised when the access type or privilege level is not permitted by the matching entry. It is also raised when a store meets an entry whose dirty flag is still clear, so that system software can record the modification. When no valid entry matches, a miss is raised. An external table walker then supplies the mapping through a refill port.

Refills have a fixed order of preference. A refill first replaces an entry that already holds the same page, then the lowest free slot. Only when the buffer is full does it evict a victim, chosen by a rotating pointer or by a pseudo-random generator, as a parameter selects. A flush input empties the whole buffer in one cycle.

Top module: `page_xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: A lookup whose page number matches a valid, permitted entry asserts hit in the same cycle, with paddr equal to {stored PPN, vaddr[11:0]}; vaddr[31:12] is the page number.
- R3: A lookup with no valid matching entry asserts miss only. Whenever hit is low, paddr is zero. When lookupValid is low, hit, miss and protFault are all low.
- R4: On a matching entry, protFault is raised instead of hit in three cases: a read (isWrite=0) to an entry without read permission, a write (isWrite=1) to an entry without write permission, or a user access (isUser=1) to an entry whose user flag is clear. Supervisor accesses ignore the user flag.
- R5: A write hit to an entry with write permission but a clear dirty flag raises protFault.
- R6: A refill to a page not already present lands in the lowest-numbered invalid entry. No valid entry is displaced while an invalid one exists.
- R7: When all entries are valid, a refill of a new page evicts a victim. In the rotating variant (RANDOM_VICTIM=0) the victim pointer starts at entry 0 and advances by one, wrapping, on each eviction. In the other variant it comes from a free-running 16-bit LFSR.
- R8: A refill whose page number is already held overwrites that entry in place and displaces no other entry.
- R9: A flush invalidates all entries at the next clock edge. A refill presented in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as a refill sees the contents before the refill; the new mapping is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A translation request is present |
| vaddr | input | 32 | Virtual address to translate |
| isWrite | input | 1 | 1 = store access, 0 = load access |
| isUser | input | 1 | 1 = user privilege, 0 = supervisor |
| flush | input | 1 | Invalidate every entry |
| fillValid | input | 1 | Refill request |
| fillVpn | input | 20 | Page number being refilled |
| fillPpn | input | 20 | Physical page number for the refill |
| fillPerm | input | 4 | {user, dirty, write, read} flags for the refill |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No valid mapping; walk required |
| protFault | output | 1 | Mapping present but access not permitted |
| paddr | output | 32 | Translated physical address (zero unless hit) |

## Verification
Two pairs of activities can fall in the same cycle: a lookup and a refill of the same page, and a flush and a refill. The bench presents a lookup of a page while that page's refill is on the port. It expects a miss before the edge and a hit after it. It also raises flush and fillValid together and expects the refilled page to miss afterwards. Eviction order, in-place refill and the full permission grid are judged against mappings computed arithmetically in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int MAX_IDX_W = 7;

  typedef struct packed {
    logic userOk;
    logic dirty;
    logic writeOk;
    logic readOk;
  } xlatPerm_t;

  typedef struct packed {
    logic                 writeEn;
    logic                 flushAll;
    logic [MAX_IDX_W-1:0] writeIdx;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES       = 32,
  parameter bit RANDOM_VICTIM = 1'b0,
  localparam int IDX_W        = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flush,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatchVec,
  output xlatStrobe_t        strobe
);
  logic             haveMatch, haveFree, evict;
  logic [IDX_W-1:0] matchIdx, freeIdx, victimIdx, chosenIdx;

  always_comb begin
    haveMatch = 1'b0;
    haveFree  = 1'b0;
    matchIdx  = '0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillMatchVec[i]) begin
        haveMatch = 1'b1;
        matchIdx  = IDX_W'(i);
      end
      if (!validVec[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
    chosenIdx = haveMatch ? matchIdx : (haveFree ? freeIdx : victimIdx);
    evict     = fillValid && !flush && !haveMatch && !haveFree;
  end

  generate
    if (RANDOM_VICTIM) begin : g_lfsr
      logic [15:0] lfsr;
      always_ff @(posedge clk) begin
        if (!rstN) lfsr <= 16'h0001;
        else       lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      assign victimIdx = IDX_W'(lfsr % 16'(ENTRIES));
    end else begin : g_fifo
      logic [IDX_W-1:0] fifoPtr;
      always_ff @(posedge clk) begin
        if (!rstN)     fifoPtr <= '0;
        else if (evict) fifoPtr <= (fifoPtr == IDX_W'(ENTRIES - 1)) ? '0 : fifoPtr + 1'b1;
      end
      assign victimIdx = fifoPtr;
    end
  endgenerate

  always_comb begin
    strobe          = '0;
    strobe.writeEn  = fillValid && !flush;
    strobe.flushAll = flush;
    strobe.writeIdx = MAX_IDX_W'(chosenIdx);
  end
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int VA_W     = 32,
  parameter int OFFSET_W = 12,
  parameter int PPN_W    = 20,
  localparam int VPN_W   = VA_W - OFFSET_W,
  localparam int PA_W    = PPN_W + OFFSET_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlatStrobe_t        strobe,
  input  logic               lookupValid,
  input  logic [VA_W-1:0]    vaddr,
  input  logic               isWrite,
  input  logic               isUser,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  xlatPerm_t          fillPerm,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fillMatchVec,
  output logic               hit,
  output logic               miss,
  output logic               protFault,
  output logic [PA_W-1:0]    paddr
);
  logic [VPN_W-1:0] entVpn  [ENTRIES];
  logic [PPN_W-1:0] entPpn  [ENTRIES];
  xlatPerm_t        entPerm [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.flushAll) begin
      validVec <= '0;
    end else if (strobe.writeEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.writeIdx == MAX_IDX_W'(i)) validVec[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeEn && !strobe.flushAll) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.writeIdx == MAX_IDX_W'(i)) begin
          entVpn[i]  <= fillVpn;
          entPpn[i]  <= fillPpn;
          entPerm[i] <= fillPerm;
        end
      end
    end
  end

  logic [VPN_W-1:0] reqVpn;
  logic             found, denied;
  logic [PPN_W-1:0] selPpn;
  xlatPerm_t        selPerm;

  assign reqVpn = vaddr[VA_W-1:OFFSET_W];

  always_comb begin
    found   = 1'b0;
    selPpn  = '0;
    selPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      fillMatchVec[i] = validVec[i] && (entVpn[i] == fillVpn);
      if (validVec[i] && (entVpn[i] == reqVpn)) begin
        found   = 1'b1;
        selPpn  = entPpn[i];
        selPerm = entPerm[i];
      end
    end
    denied = (isUser && !selPerm.userOk)
           || (!isWrite && !selPerm.readOk)
           || (isWrite && (!selPerm.writeOk || !selPerm.dirty));
    hit       = lookupValid && found && !denied;
    protFault = lookupValid && found && denied;
    miss      = lookupValid && !found;
    paddr     = hit ? {selPpn, vaddr[OFFSET_W-1:0]} : '0;
  end
endmodule

// File: rtl/page_xlat_cache.sv
module page_xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES       = 32,
  parameter int VA_W          = 32,
  parameter int OFFSET_W      = 12,
  parameter int PPN_W         = 20,
  parameter bit RANDOM_VICTIM = 1'b0,
  localparam int VPN_W        = VA_W - OFFSET_W,
  localparam int PA_W         = PPN_W + OFFSET_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             isWrite,
  input  logic             isUser,
  input  logic             flush,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [3:0]       fillPerm,
  output logic             hit,
  output logic             miss,
  output logic             protFault,
  output logic [PA_W-1:0]  paddr
);
  xlatStrobe_t        strobe;
  logic [ENTRIES-1:0] validVec, fillMatchVec;

  xlat_ctrl #(.ENTRIES(ENTRIES), .RANDOM_VICTIM(RANDOM_VICTIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flush(flush),
    .validVec(validVec), .fillMatchVec(fillMatchVec), .strobe(strobe)
  );

  xlat_datapath #(.ENTRIES(ENTRIES), .VA_W(VA_W), .OFFSET_W(OFFSET_W), .PPN_W(PPN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupValid(lookupValid),
    .vaddr(vaddr), .isWrite(isWrite), .isUser(isUser), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillPerm(xlatPerm_t'(fillPerm)), .validVec(validVec),
    .fillMatchVec(fillMatchVec), .hit(hit), .miss(miss), .protFault(protFault),
    .paddr(paddr)
  );
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int VA_W     = 32,
  parameter int OFFSET_W = 12,
  parameter int PPN_W    = 20
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     lookupValid,
  input logic [VA_W-1:0]          vaddr,
  input logic                     isWrite,
  input logic                     flush,
  input logic                     fillValid,
  input logic [VA_W-OFFSET_W-1:0] fillVpn,
  input logic [3:0]               fillPerm,
  input logic                     hit,
  input logic                     miss,
  input logic                     protFault,
  input logic [PPN_W+OFFSET_W-1:0] paddr
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $countones({hit, miss, protFault}) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit && !miss && !protFault); // R3
  AST_NO_ADDR_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> paddr == '0); // R3
  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> paddr[OFFSET_W-1:0] == vaddr[OFFSET_W-1:0]); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (lookupValid |-> miss)); // R9
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush) |=>
      ((lookupValid && !flush && vaddr[VA_W-1:OFFSET_W] == $past(fillVpn)) |-> !miss)); // R10
  AST_CLEAN_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush && fillPerm == 4'b0011) |=>
      ((lookupValid && isWrite && vaddr[VA_W-1:OFFSET_W] == $past(fillVpn)) |-> protFault)); // R5
endmodule

bind page_xlat_cache xlat_checker #(.VA_W(VA_W), .OFFSET_W(OFFSET_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .vaddr(vaddr), .isWrite(isWrite),
  .flush(flush), .fillValid(fillValid), .fillVpn(fillVpn), .fillPerm(fillPerm),
  .hit(hit), .miss(miss), .protFault(protFault), .paddr(paddr)
);

// File: tb/page_xlat_cache_bench.sv
module page_xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, isWrite = 1'b0, isUser = 1'b0, flush = 1'b0, fillValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [19:0] fillVpn = '0, fillPpn = '0;
  logic [3:0]  fillPerm = '0;
  logic        hit, miss, protFault;
  logic [31:0] paddr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_xlat_cache u_page_xlat_cache (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .vaddr(vaddr), .isWrite(isWrite),
    .isUser(isUser), .flush(flush), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillPerm(fillPerm), .hit(hit), .miss(miss),
    .protFault(protFault), .paddr(paddr)
  );

  function automatic logic [19:0] vpnOf(int i);  return 20'h00100 + 20'(i * 37); endfunction
  function automatic logic [19:0] ppnOf(int i);  return 20'hA0000 ^ 20'(i * 1031); endfunction
  function automatic logic [11:0] offOf(int i);  return 12'(i * 13 + 5); endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] perm);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = v; fillPpn = p; fillPerm = perm;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // Applies a lookup at a negedge and samples halfway to the next edge.
  task automatic look(input logic [19:0] v, input logic [11:0] off, input bit wr, input bit usr);
    @(negedge clk);
    lookupValid = 1'b1; vaddr = {v, off}; isWrite = wr; isUser = usr;
    #5;
  endtask

  task automatic expectHit(input logic [19:0] v, input logic [19:0] p, input logic [11:0] off, input string req);
    look(v, off, 1'b0, 1'b0);
    check(hit && !miss && !protFault && paddr == {p, off}, req,
          {hit, miss, protFault, 1'b0, paddr}, {4'b1000, p, off});
  endtask

  task automatic expectMiss(input logic [19:0] v, input string req);
    look(v, 12'h123, 1'b0, 1'b0);
    check(!hit && miss && !protFault && paddr == '0, req,
          {hit, miss, protFault, 1'b0, paddr}, {4'b0100, 32'h0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    expectMiss(vpnOf(0), "R1");
    expectMiss(vpnOf(5), "R1");
    // R3: idle lookup produces nothing
    @(negedge clk); lookupValid = 1'b0; #5;
    check(!hit && !miss && !protFault && paddr == '0, "R3 idle", {hit, miss, protFault}, 3'b000);

    // R6: 32 refills into invalid slots, none displaced
    for (int i = 0; i < 32; i++) doFill(vpnOf(i), ppnOf(i), 4'b1111);
    for (int i = 0; i < 32; i++) expectHit(vpnOf(i), ppnOf(i), offOf(i), "R6/R2 full fill");

    // R7: FIFO eviction from entry 0 then entry 1
    doFill(20'hFFFF0, 20'h11111, 4'b1111);
    expectMiss(vpnOf(0), "R7 first victim");
    expectHit(20'hFFFF0, 20'h11111, 12'hABC, "R7 new page");
    expectHit(vpnOf(1), ppnOf(1), 12'h001, "R7 survivor");
    doFill(20'hFFFF1, 20'h22222, 4'b1111);
    expectMiss(vpnOf(1), "R7 second victim");
    expectHit(20'hFFFF1, 20'h22222, 12'hFFF, "R7 new page 2");

    // R8: refill existing page in place
    doFill(vpnOf(5), 20'h33333, 4'b1111);
    expectHit(vpnOf(5), 20'h33333, 12'h050, "R8 updated");
    expectHit(vpnOf(2), ppnOf(2), 12'h002, "R8 no eviction");

    // R10: lookup and refill in the same cycle
    @(negedge clk);
    fillValid = 1'b1; fillVpn = 20'hFFFF2; fillPpn = 20'h44444; fillPerm = 4'b1111;
    lookupValid = 1'b1; vaddr = {20'hFFFF2, 12'h777}; isWrite = 1'b0; isUser = 1'b0;
    #5;
    check(miss && !hit, "R10 same cycle", {hit, miss}, 2'b01);
    @(negedge clk); fillValid = 1'b0; #5;
    check(hit && paddr == {20'h44444, 12'h777}, "R10 next cycle", paddr, {20'h44444, 12'h777});

    // R9: flush clears everything; flush beats a simultaneous refill
    doFlush();
    expectMiss(vpnOf(3), "R9 flushed");
    expectMiss(20'hFFFF0, "R9 flushed");
    @(negedge clk);
    flush = 1'b1; fillValid = 1'b1; fillVpn = 20'h55555; fillPpn = 20'h66666; fillPerm = 4'b1111;
    @(negedge clk); flush = 1'b0; fillValid = 1'b0;
    expectMiss(20'h55555, "R9 flush beats fill");

    // R4/R5: permission grid, entries {user,dirty,write,read}
    for (int c = 0; c < 16; c++) doFill(20'h08000 + 20'(c), 20'h0C000 + 20'(c), 4'(c));
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 4; a++) begin
        bit wr, usr, flt;
        wr  = a[0]; usr = a[1];
        flt = (usr && !c[3]) || (!wr && !c[0]) || (wr && (!c[1] || !c[2]));
        look(20'h08000 + 20'(c), offOf(c + a), wr, usr);
        check(hit == !flt && protFault == flt && !miss &&
              paddr == (flt ? 32'h0 : {20'h0C000 + 20'(c), offOf(c + a)}),
              (wr && c[1] && !c[2]) ? "R5 clean write" : "R4 permission",
              {hit, miss, protFault, 1'b0, paddr}, {!flt, 1'b0, flt, 1'b0, 32'h0});
      end
    end
    @(negedge clk); lookupValid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule